// File: doc/BRIEF.md
# Phase-Tracked Frame Interface Clock Generator

This block produces the clocks of a serial frame interface from one fast master clock. The master clock runs at twice the reference rate, so one master tick is half a reference period. In terminal mode the block builds a bit clock of ten ticks per cycle. It also builds a half-rate auxiliary clock and a frame sync of 192 bit cycles. The bit clock is held in step with a receive-frame strobe. A phase detector records whether the strobe came early, late or on time relative to the internal frame position. Once per correction slot of two frames, that decision stretches or shrinks the high phase of a single bit-clock cycle by one tick.

Two mode inputs pick the operating mode. When `mode_line` is low the block runs in terminal mode, and `mode_local` has no effect. When `mode_line` is high the block runs in one of two line modes. In these modes the bit-clock and frame-sync outputs are parked low, and the auxiliary output carries one of two clocks. If `mode_local` is high, it carries the locally generated bit-rate clock with no tracking. If `mode_local` is low, it carries an external line clock divided by two.

Top module: `iclk_gen`

## Requirements
- R1: While `rst_n` is low, all three outputs are low and no correction is pending, so the first high phase after reset lasts 5 ticks.
- R2: In terminal mode every low phase of `bit_clk_o` lasts exactly 5 ticks, and an uncorrected high phase lasts 5 ticks.
- R3: A `ref_strobe` seen while the internal bit index within the frame is in 1..95 makes the high phase of bit 0 of the next slot last 6 ticks.
- R4: A `ref_strobe` seen while the bit index is in 96..191 makes that high phase last 4 ticks.
- R5: A strobe seen at bit index 0 is in phase and requests no correction. Within one slot, the latest strobe's decision replaces any earlier one.
- R6: A slot is 384 bit cycles (2 frames), starting with the first bit after reset. A correction can only touch the high phase of bit 0 of a slot. The pending decision is cleared when that bit rises, so a slot with no new strobe gets 5 ticks.
- R7: In terminal mode `aux_clk_o` toggles at every rising edge of `bit_clk_o` and at no other time; it is high after the first rise.
- R8: In terminal mode `frame_sync_o` is high for bits 0..63 of each 192-bit frame and low for bits 64..191. It changes together with the falling edge of `bit_clk_o` that ends the previous bit, and is high during bit 0 right after reset.
- R9: With `mode_line` low, terminal mode applies whatever the level of `mode_local`.
- R10: With `mode_line` high and `mode_local` high, `bit_clk_o` and `frame_sync_o` stay low. `aux_clk_o` is a 5-tick high / 5-tick low clock, and `ref_strobe` has no effect on it.
- R11: With `mode_line` high and `mode_local` low, `bit_clk_o` and `frame_sync_o` stay low. `aux_clk_o` toggles once per rising edge of `line_clk`, so each of its phases lasts one full `line_clk` period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, twice the reference rate |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_line | input | 1 | 0: terminal mode, 1: line modes |
| mode_local | input | 1 | Line-mode select: 1 local clock, 0 divided line clock |
| ref_strobe | input | 1 | Single-cycle receive-frame reference strobe |
| line_clk | input | 1 | External line data clock (asynchronous) |
| bit_clk_o | output | 1 | Tracked bit clock (terminal mode) |
| aux_clk_o | output | 1 | Half-rate clock, local clock or divided line clock |
| frame_sync_o | output | 1 | Frame sync, 1:2 high-to-low |

## Verification
A wrong pending decision or slot counter shows up at exactly one bit-clock high phase: the first bit of the next slot, at most 384 bit cycles after the strobe. That phase is 4 or 6 ticks long where 5 was due, or 5 where a correction was due. A pending decision that is never cleared shows up one slot later as an extra corrected phase. A slipped bit or frame counter moves the frame-sync edges away from bit 0 and bit 64 within one frame. A wrong toggle on the half-rate clock breaks its one-toggle-per-rise relation at the next bit-clock edge. In the line modes, any leak from the tracking logic shows as a non-5-tick phase on the auxiliary output. A faulty divider shows as a phase that differs from the line-clock period.

// File: rtl/iclk_pkg.sv
package iclk_pkg;

    // Correction request carried from the phase detector to the generator
    typedef enum logic [1:0] {
        CORR_NONE    = 2'd0,
        CORR_STRETCH = 2'd1,
        CORR_SHRINK  = 2'd2
    } corr_e;

endpackage

// File: rtl/iclk_frame_gen.sv
module iclk_frame_gen
    import iclk_pkg::*;
#(
    parameter int HALF_TICKS      = 5,
    parameter int BITS_PER_FRAME  = 192,
    parameter int FRAMES_PER_SLOT = 2,
    localparam int CW = $clog2(HALF_TICKS + 2),
    localparam int BW = $clog2(BITS_PER_FRAME),
    localparam int FW = (FRAMES_PER_SLOT > 1) ? $clog2(FRAMES_PER_SLOT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          track_en,
    input  corr_e         corr,
    output logic          consume,
    output logic          lvl_d,
    output logic          half_d,
    output logic [BW-1:0] bit_q,
    output logic [BW-1:0] bit_d
);

    typedef struct packed {
        logic          lvl;
        logic          half;
        logic [CW-1:0] cnt;
        logic [CW-1:0] hi_len;
        logic [BW-1:0] bit_idx;
        logic [FW-1:0] frm;
    } gen_t;

    gen_t s_q, s_d;

    always_comb begin
        s_d     = s_q;
        consume = 1'b0;
        if (!s_q.lvl) begin
            if (s_q.cnt == CW'(HALF_TICKS - 1)) begin
                s_d.lvl    = 1'b1;
                s_d.cnt    = '0;
                s_d.half   = ~s_q.half;
                s_d.hi_len = CW'(HALF_TICKS);
                if (track_en && (s_q.bit_idx == '0) && (s_q.frm == '0)) begin
                    consume = 1'b1;
                    case (corr)
                        CORR_STRETCH: s_d.hi_len = CW'(HALF_TICKS + 1);
                        CORR_SHRINK:  s_d.hi_len = CW'(HALF_TICKS - 1);
                        default:      s_d.hi_len = CW'(HALF_TICKS);
                    endcase
                end
            end else begin
                s_d.cnt = s_q.cnt + CW'(1);
            end
        end else begin
            if (s_q.cnt == s_q.hi_len - CW'(1)) begin
                s_d.lvl = 1'b0;
                s_d.cnt = '0;
                if (s_q.bit_idx == BW'(BITS_PER_FRAME - 1)) begin
                    s_d.bit_idx = '0;
                    s_d.frm     = (s_q.frm == FW'(FRAMES_PER_SLOT - 1)) ? '0 : s_q.frm + FW'(1);
                end else begin
                    s_d.bit_idx = s_q.bit_idx + BW'(1);
                end
            end else begin
                s_d.cnt = s_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.hi_len <= CW'(HALF_TICKS);
        end else begin
            s_q <= s_d;
        end
    end

    assign lvl_d  = s_d.lvl;
    assign half_d = s_d.half;
    assign bit_q  = s_q.bit_idx;
    assign bit_d  = s_d.bit_idx;

endmodule

// File: rtl/iclk_phase_det.sv
module iclk_phase_det
    import iclk_pkg::*;
#(
    parameter int BITS_PER_FRAME = 192,
    localparam int BW = $clog2(BITS_PER_FRAME)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          track_en,
    input  logic          strobe,
    input  logic          consume,
    input  logic [BW-1:0] bit_idx,
    output corr_e         pend_q
);

    corr_e pend_d;
    corr_e decision;

    always_comb begin
        if (bit_idx == '0)
            decision = CORR_NONE;
        else if (bit_idx < BW'(BITS_PER_FRAME / 2))
            decision = CORR_STRETCH;
        else
            decision = CORR_SHRINK;

        pend_d = pend_q;
        if (consume)
            pend_d = CORR_NONE;
        if (track_en && strobe)
            pend_d = decision;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= CORR_NONE;
        else        pend_q <= pend_d;
    end

endmodule

// File: rtl/iclk_line_div.sv
module iclk_line_div #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_clk,
    output logic div_d
);

    typedef struct packed {
        logic [SYNC_STAGES:0] sh;
        logic                 div;
    } div_t;

    div_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        r_d.sh  = {r_q.sh[SYNC_STAGES-1:0], line_clk};
        r_d.div = r_q.div ^ (r_q.sh[SYNC_STAGES-1] & ~r_q.sh[SYNC_STAGES]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign div_d = r_d.div;

endmodule

// File: rtl/iclk_gen.sv
module iclk_gen
    import iclk_pkg::*;
#(
    parameter int HALF_TICKS      = 5,
    parameter int BITS_PER_FRAME  = 192,
    parameter int FRAMES_PER_SLOT = 2,
    parameter int SYNC_STAGES     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_line,
    input  logic mode_local,
    input  logic ref_strobe,
    input  logic line_clk,
    output logic bit_clk_o,
    output logic aux_clk_o,
    output logic frame_sync_o
);

    localparam int BW      = $clog2(BITS_PER_FRAME);
    localparam int FS_BITS = BITS_PER_FRAME / 3;

    typedef struct packed {
        logic bclk;
        logic aux;
        logic fsync;
    } out_t;

    logic          term;
    logic          consume;
    logic          lvl_d;
    logic          half_d;
    logic          div_d;
    logic [BW-1:0] bit_q;
    logic [BW-1:0] bit_d;
    corr_e         pend;
    out_t          o_q, o_d;

    assign term = ~mode_line;

    iclk_frame_gen #(
        .HALF_TICKS     (HALF_TICKS),
        .BITS_PER_FRAME (BITS_PER_FRAME),
        .FRAMES_PER_SLOT(FRAMES_PER_SLOT)
    ) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .track_en(term),
        .corr    (pend),
        .consume (consume),
        .lvl_d   (lvl_d),
        .half_d  (half_d),
        .bit_q   (bit_q),
        .bit_d   (bit_d)
    );

    iclk_phase_det #(
        .BITS_PER_FRAME(BITS_PER_FRAME)
    ) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .track_en(term),
        .strobe  (ref_strobe),
        .consume (consume),
        .bit_idx (bit_q),
        .pend_q  (pend)
    );

    iclk_line_div #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_clk(line_clk),
        .div_d   (div_d)
    );

    always_comb begin
        o_d.bclk  = term & lvl_d;
        o_d.fsync = term & (bit_d < BW'(FS_BITS));
        if (term)
            o_d.aux = half_d;
        else if (mode_local)
            o_d.aux = lvl_d;
        else
            o_d.aux = div_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign bit_clk_o    = o_q.bclk;
    assign aux_clk_o    = o_q.aux;
    assign frame_sync_o = o_q.fsync;

endmodule

module iclk_gen_chk #(
    parameter int HALF_TICKS = 5
) (
    input logic clk,
    input logic rst_n,
    input logic mode_line,
    input logic bit_clk_o,
    input logic aux_clk_o,
    input logic frame_sync_o
);

    logic       prev_q;
    logic       seen_fall_q;
    logic [7:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q      <= 1'b0;
            seen_fall_q <= 1'b0;
            run_q       <= '0;
        end else begin
            prev_q <= bit_clk_o;
            if (prev_q && !bit_clk_o) seen_fall_q <= 1'b1;
            if (bit_clk_o != prev_q)  run_q <= 8'd1;
            else if (run_q != 8'hff)  run_q <= run_q + 8'd1;
        end
    end

    // R2
    low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_line && $rose(bit_clk_o) && seen_fall_q) |-> (run_q == 8'(HALF_TICKS)));

    // R3 R4
    high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_line && $fell(bit_clk_o)) |->
            ((run_q >= 8'(HALF_TICKS - 1)) && (run_q <= 8'(HALF_TICKS + 1))));

    // R7
    aux_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_line && $rose(bit_clk_o)) |-> (aux_clk_o != $past(aux_clk_o)));

    // R7
    aux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_line && !$rose(bit_clk_o)) |-> $stable(aux_clk_o));

    // R8
    fsync_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_line && $fell(frame_sync_o)) |-> $fell(bit_clk_o));

    // R10 R11
    line_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_line |=> (!bit_clk_o && !frame_sync_o));

endmodule

bind iclk_gen iclk_gen_chk #(.HALF_TICKS(HALF_TICKS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_line   (mode_line),
    .bit_clk_o   (bit_clk_o),
    .aux_clk_o   (aux_clk_o),
    .frame_sync_o(frame_sync_o)
);

// File: tb/tb_iclk_gen.sv
`timescale 1ns/1ps
module tb_iclk_gen;

    localparam int SLOT_BITS  = 384;
    localparam int FRAME_BITS = 192;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_line = 1'b0;
    logic mode_local = 1'b1;
    logic ref_strobe = 1'b0;
    logic line_clk = 1'b0;
    logic bit_clk_o, aux_clk_o, frame_sync_o;

    always #4 clk = ~clk;

    iclk_gen dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_line   (mode_line),
        .mode_local  (mode_local),
        .ref_strobe  (ref_strobe),
        .line_clk    (line_clk),
        .bit_clk_o   (bit_clk_o),
        .aux_clk_o   (aux_clk_o),
        .frame_sync_o(frame_sync_o)
    );

    typedef struct { int idx; int len; } exp_t;
    exp_t exp_q[$];

    int checks = 0;
    int errors = 0;
    int phase  = 0;
    int rise_cnt = 0;
    int hi_run = 0, lo_run = 0;
    bit prev_lvl = 0, seen_fall = 0, last_aux = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Driver: one strobe in bit n, expected item pushed for the next slot start
    task automatic strobe_at(input int n);
        exp_t e;
        int pos;
        do @(posedge clk); while (rise_cnt < n + 1);
        @(negedge clk) ref_strobe = 1'b1;
        @(negedge clk) ref_strobe = 1'b0;
        pos   = n % FRAME_BITS;
        e.idx = (n / SLOT_BITS + 1) * SLOT_BITS;
        e.len = (pos == 0) ? 5 : (pos < FRAME_BITS / 2) ? 6 : 4;
        if (exp_q.size() > 0 && exp_q[$].idx == e.idx) exp_q[$].len = e.len;
        else exp_q.push_back(e);
    endtask

    task automatic do_reset(input bit ml, input bit mc, input int ph);
        rst_n = 1'b0;
        mode_line = ml;
        mode_local = mc;
        repeat (4) @(negedge clk);
        phase = ph;
        chk(!bit_clk_o && !aux_clk_o && !frame_sync_o, "R1 outputs low in reset",
            {bit_clk_o, aux_clk_o, frame_sync_o}, 0);
        rst_n = 1'b1;
    endtask

    // Monitor: measures phases and pops expected high lengths
    always @(negedge clk) begin
        logic sig;
        int expv;
        string tag;
        if (!rst_n) begin
            rise_cnt = 0; hi_run = 0; lo_run = 0;
            prev_lvl = 0; seen_fall = 0; last_aux = 0;
        end else begin
            sig = (phase == 0) ? bit_clk_o : aux_clk_o;
            if (sig && !prev_lvl) begin
                if (phase == 0) begin
                    chk(aux_clk_o == !last_aux, "R7 aux toggles at rise", aux_clk_o, !last_aux);
                    last_aux = aux_clk_o;
                    chk(frame_sync_o == ((rise_cnt % FRAME_BITS) < 64), "R8 frame sync",
                        frame_sync_o, ((rise_cnt % FRAME_BITS) < 64));
                    if (seen_fall) chk(lo_run == 5, "R2 low phase", lo_run, 5);
                end else begin
                    chk(!bit_clk_o && !frame_sync_o, (phase == 1) ? "R10 quiet" : "R11 quiet",
                        {bit_clk_o, frame_sync_o}, 0);
                    if (phase == 1 && seen_fall) chk(lo_run == 5, "R10 low phase", lo_run, 5);
                    if (phase == 2 && seen_fall) chk(lo_run == 16, "R11 low phase", lo_run, 16);
                end
                rise_cnt++;
                hi_run = 1;
                lo_run = 0;
            end else if (!sig && prev_lvl) begin
                if (phase == 0) begin
                    expv = 5;
                    tag  = (rise_cnt == 1) ? "R1 first high" : "R6 uncorrected high";
                    if (exp_q.size() > 0 && exp_q[0].idx == rise_cnt - 1) begin
                        expv = exp_q[0].len;
                        tag  = (expv == 6) ? "R3 stretched high" :
                               (expv == 4) ? "R4 shrunk high" : "R5 in-phase high";
                        void'(exp_q.pop_front());
                    end
                    chk(hi_run == expv, tag, hi_run, expv);
                end else if (phase == 1) begin
                    chk(hi_run == 5, "R10 high phase", hi_run, 5);
                end else begin
                    chk(hi_run == 16, "R11 high phase", hi_run, 16);
                end
                seen_fall = 1;
                lo_run = 1;
                hi_run = 0;
            end else if (sig) begin
                hi_run++;
            end else begin
                lo_run++;
            end
            prev_lvl = sig;
        end
    end

    initial begin
        // Terminal mode with mode_local high (R9)
        do_reset(1'b0, 1'b1, 0);
        strobe_at(10);
        strobe_at(534);
        strobe_at(776);
        strobe_at(1068);
        strobe_at(1192);
        strobe_at(1344);
        do @(posedge clk); while (rise_cnt < 2000);
        chk(exp_q.size() == 0, "R6 all corrections applied", exp_q.size(), 0);
        chk(rise_cnt >= 2000, "R9 terminal mode active", rise_cnt, 2000);

        // Line mode, local clock
        do_reset(1'b1, 1'b1, 1);
        for (int k = 0; k < 18; k++) begin
            repeat (500) @(negedge clk);
            ref_strobe = 1'b1;
            @(negedge clk) ref_strobe = 1'b0;
        end
        chk(rise_cnt > 800, "R10 aux clock running", rise_cnt, 800);

        // Line mode, divided line clock
        do_reset(1'b1, 1'b0, 2);
        for (int k = 0; k < 20; k++) begin
            repeat (8) @(negedge clk);
            line_clk = 1'b1;
            repeat (8) @(negedge clk);
            line_clk = 1'b0;
        end
        repeat (20) @(negedge clk);
        chk(rise_cnt == 10, "R11 one toggle per line rise", rise_cnt, 10);
        chk(!aux_clk_o, "R11 final aux level", aux_clk_o, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule